// File: doc/BRIEF.md
# GPIO Interrupt Trigger and Status Unit

This unit turns a bank of general-purpose input pins into a single interrupt request. Every pin owns two mode bits that select what counts as an event on that pin. The four modes are rising edge, falling edge, low level and high level. Pin levels arrive asynchronously and pass through a two-stage synchronizer. A third flop keeps the previous synchronized sample, and edges are detected by comparing against it.

Detected events set bits in a sticky status bitmap. Software clears a status bit by writing a 1 to it. A separate enable bitmap masks the status bits. Both bitmaps are packed 32 pins to a word. The combined interrupt output is the registered OR, over all words, of status AND enable.

A per-pin sense-off input stops a pin from raising new status. The register bus decoder sits outside the block and delivers plain write strobes with an address and a data word.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every status bit, every enable bit and the irq output are 0.
- R2: Mode bits {trig_level, trig_invert} = 2'b00 select rising edge. In this mode, only a 0-to-1 change of the synchronized pin sets the status bit. A held high level or a falling edge sets nothing.
- R3: Mode bits 2'b01 select falling edge. In this mode, only a 1-to-0 change sets the status bit.
- R4: Mode bits 2'b10 select low level and 2'b11 select high level. The status bit is set on every cycle the active level is present. When a write-1-to-clear and a new event hit the same bit in the same cycle, the bit stays set. The bit stays set after the level goes away, until it is cleared.
- R5: A write to byte address 0x80 + 4*n clears the status bits of word n that are 1 in the data. Bits written as 0 keep their value. Bit k of word n is pin 32*n + k.
- R6: A write to 0x90 + 4*n replaces enable word n and leaves the other words unchanged. Writes to any other address change neither bitmap.
- R7: irq goes high one cycle after some pin has both its status bit and its enable bit set. It falls one cycle after no such pin remains. A status bit whose enable bit is 0 never raises irq.
- R8: A pin whose sense_off bit is 1 sets no new status bit, in any mode. When sense_off is released while an edge-mode pin is already at its new level, no event is produced.
- R9: A pin change driven just after a clock edge appears in the status bit after the third rising clock edge and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 95 | Raw pin levels |
| trig_level | input | 95 | Per-pin detection type: 0 edge, 1 level |
| trig_invert | input | 95 | Per-pin polarity bit (see R2 to R4) |
| sense_off | input | 95 | Per-pin input sensing disable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| stat_bits | output | 95 | Sticky status bitmap |
| en_bits | output | 95 | Enable bitmap |
| irq | output | 1 | Combined registered interrupt request |

## Verification
The bench targets the polarity split between the modes. With the invert bit clear, edge mode fires on rising edges and level mode fires on a low level. A design that applied one polarity to both would set status in the idle high-level and low-level tests, or miss them.

Clearing a status bit while a high level is still present must leave the bit set. A design that let the clear win would show a dropped bit for one cycle.

The bench checks the exact synchronizer latency and the one-cycle lag of irq, both when raising and when masking. Bad counting would show up as early or late status. The bench also releases sense_off while the pin is already high. A design that reset its previous sample under sense-off would report a phantom edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Byte offsets of the bitmap words seen by the register decoder.
    localparam int STAT_BASE  = 32'h80;
    localparam int EN_BASE    = 32'h90;
    localparam int WORD_BYTES = 4;

    // Detection type, encoded as {trig_level, trig_invert}.
    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_mode_e;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int WIDTH = 95
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_raw,
    output logic [WIDTH-1:0] lvl_now,
    output logic [WIDTH-1:0] lvl_prev
);

    logic [WIDTH-1:0] meta_q;

    // Two stages of synchronization plus one stage of history for edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            lvl_now  <= '0;
            lvl_prev <= '0;
        end else begin
            meta_q   <= pin_raw;
            lvl_now  <= meta_q;
            lvl_prev <= lvl_now;
        end
    end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 95
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] lvl_now,
    input  logic [NUM_PINS-1:0] lvl_prev,
    input  logic [NUM_PINS-1:0] trig_level,
    input  logic [NUM_PINS-1:0] trig_invert,
    input  logic [NUM_PINS-1:0] sense_off,
    output logic [NUM_PINS-1:0] evt
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        trig_mode_e mode;
        logic       hit;

        assign mode = trig_mode_e'({trig_level[i], trig_invert[i]});

        always_comb begin
            hit = 1'b0;
            unique case (mode)
                TRIG_RISE: hit = lvl_now[i] & ~lvl_prev[i];
                TRIG_FALL: hit = ~lvl_now[i] & lvl_prev[i];
                TRIG_LOW:  hit = ~lvl_now[i];
                TRIG_HIGH: hit = lvl_now[i];
            endcase
        end

        assign evt[i] = hit & ~sense_off[i];

        // R2/R3: an edge-mode event needs a change between samples
        assert_edge_needs_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[i] && !trig_level[i]) |-> (lvl_now[i] != lvl_prev[i]));

        // R4: a level-mode event matches the level picked by the invert bit
        assert_level_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[i] && trig_level[i]) |-> (lvl_now[i] == trig_invert[i]));
    end

endmodule

// File: rtl/gpio_irq_word.sv
module gpio_irq_word
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 8,
    parameter int IDX    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [WIDTH-1:0]  evt,
    input  logic [WIDTH-1:0]  sense_off,
    output logic [WIDTH-1:0]  stat_q,
    output logic [WIDTH-1:0]  en_q,
    output logic              pend
);

    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_BASE + IDX * WORD_BYTES);
    localparam logic [ADDR_W-1:0] EN_ADDR   = ADDR_W'(EN_BASE + IDX * WORD_BYTES);

    logic             stat_we;
    logic             en_we;
    logic [WIDTH-1:0] clr_mask;

    assign stat_we  = wr_en && (wr_addr == STAT_ADDR);
    assign en_we    = wr_en && (wr_addr == EN_ADDR);
    assign clr_mask = stat_we ? wr_data : '0;

    // A fresh event overrides a clear aimed at the same bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_mask) | evt;
            if (en_we) begin
                en_q <= wr_data;
            end
        end
    end

    assign pend = |(stat_q & en_q);

    // R5: bits written 1 with no competing event are clear afterwards
    assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we |=> ((stat_q & $past(wr_data & ~evt)) == '0));

    // R6: an enable write lands the whole data word
    assert_en_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> (en_q == $past(wr_data)));

    // R8: no status bit rises on a pin whose sensing was off
    assert_no_set_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & $past(sense_off)) == '0));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 95,
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] trig_level,
    input  logic [NUM_PINS-1:0] trig_invert,
    input  logic [NUM_PINS-1:0] sense_off,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [NUM_PINS-1:0] stat_bits,
    output logic [NUM_PINS-1:0] en_bits,
    output logic                irq
);

    localparam int NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;

    logic [NUM_PINS-1:0]  lvl_now;
    logic [NUM_PINS-1:0]  lvl_prev;
    logic [NUM_PINS-1:0]  evt;
    logic [NUM_WORDS-1:0] pend;

    gpio_irq_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_in),
        .lvl_now  (lvl_now),
        .lvl_prev (lvl_prev)
    );

    gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_now     (lvl_now),
        .lvl_prev    (lvl_prev),
        .trig_level  (trig_level),
        .trig_invert (trig_invert),
        .sense_off   (sense_off),
        .evt         (evt)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam int LO = w * WORD_W;
        localparam int VB = ((NUM_PINS - LO) > WORD_W) ? WORD_W : (NUM_PINS - LO);

        gpio_irq_word #(
            .WIDTH  (VB),
            .ADDR_W (ADDR_W),
            .IDX    (w)
        ) u_word (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en),
            .wr_addr   (wr_addr),
            .wr_data   (wr_data[VB-1:0]),
            .evt       (evt[LO +: VB]),
            .sense_off (sense_off[LO +: VB]),
            .stat_q    (stat_bits[LO +: VB]),
            .en_q      (en_bits[LO +: VB]),
            .pend      (pend[w])
        );
    end

    // Registered combine keeps the wide OR off the interrupt path.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= |pend;
        end
    end

    // R7: irq tracks the masked status one cycle later
    assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(stat_bits & en_bits))));

endmodule

// File: tb/gpio_irq_unit_bench.sv
`timescale 1ns/1ps
module gpio_irq_unit_bench;

    localparam int NP = 95;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] trig_level = '0;
    logic [NP-1:0] trig_invert = '0;
    logic [NP-1:0] sense_off = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [NP-1:0] stat_bits;
    logic [NP-1:0] en_bits;
    logic          irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    typedef struct {
        string         tag;
        logic [NP-1:0] st;
        logic [NP-1:0] en;
        logic          irq;
    } exp_t;

    exp_t q[$];
    event chk_ev;

    logic [NP-1:0] es;
    logic [NP-1:0] ee;

    gpio_irq_unit u_gpio_irq_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_in      (pin_in),
        .trig_level  (trig_level),
        .trig_invert (trig_invert),
        .sense_off   (sense_off),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .stat_bits   (stat_bits),
        .en_bits     (en_bits),
        .irq         (irq)
    );

    always #2.5 clk = ~clk;

    function automatic logic [NP-1:0] bit_at(input int k);
        logic [NP-1:0] v;
        v = '0;
        v[k] = 1'b1;
        return v;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Driver side of the scoreboard: queue an expected output state.
    task automatic expect_state(input string tag, input logic x_irq);
        exp_t e;
        e.tag = tag;
        e.st  = es;
        e.en  = ee;
        e.irq = x_irq;
        q.push_back(e);
        -> chk_ev;
    endtask

    // Monitor side: pop and compare against the ports.
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (stat_bits !== e.st || en_bits !== e.en || irq !== e.irq) begin
                    errors++;
                    $display("FAIL %s: got stat=%h en=%h irq=%b, expected stat=%h en=%h irq=%b",
                             e.tag, stat_bits, en_bits, irq, e.st, e.en, e.irq);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        es = '0;
        ee = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_state("R1 in reset", 1'b0);
        rst_n = 1'b1;
        tick(1);
        expect_state("R1 after reset", 1'b0);

        // R6: enable every pin
        wr(8'h90, 32'hFFFF_FFFF);
        wr(8'h94, 32'hFFFF_FFFF);
        wr(8'h98, 32'hFFFF_FFFF);
        ee = '1;
        expect_state("R6 enable all", 1'b0);

        // R9 / R2: rising edge on pin 3, exact latency
        pin_in[3] = 1'b1;
        tick(2);
        expect_state("R9 not yet visible", 1'b0);
        tick(1);
        es = bit_at(3);
        expect_state("R9 third edge", 1'b0);
        tick(1);
        expect_state("R7 irq one cycle later", 1'b1);

        // R5: zero write keeps, one write clears
        wr(8'h80, 32'h0);
        expect_state("R5 zero write keeps", 1'b1);
        wr(8'h80, 32'h8);
        es = '0;
        expect_state("R5 clear bit", 1'b1);
        tick(1);
        expect_state("R7 irq drops", 1'b0);
        tick(3);
        expect_state("R2 held high no retrigger", 1'b0);
        pin_in[3] = 1'b0;
        tick(4);
        expect_state("R2 falling ignored", 1'b0);

        // R3: falling edge on pin 40
        trig_invert[40] = 1'b1;
        pin_in[40] = 1'b1;
        tick(4);
        expect_state("R3 rising ignored", 1'b0);
        pin_in[40] = 1'b0;
        tick(3);
        es = bit_at(40);
        expect_state("R3 falling sets", 1'b0);
        wr(8'h84, 32'h100);
        es = '0;
        expect_state("R5 clear word1", 1'b1);
        tick(1);
        expect_state("R7 drop after clear", 1'b0);

        // R7: masked status raises no irq
        wr(8'h94, 32'h0);
        ee[63:32] = '0;
        pin_in[40] = 1'b1;
        tick(2);
        pin_in[40] = 1'b0;
        tick(4);
        es = bit_at(40);
        expect_state("R7 masked no irq", 1'b0);
        wr(8'h94, 32'h100);
        ee[40] = 1'b1;
        expect_state("R6 enable bit40", 1'b0);
        tick(1);
        expect_state("R7 irq on enable", 1'b1);
        wr(8'h84, 32'h100);
        es = '0;
        expect_state("R5 clear bit40", 1'b1);
        tick(1);
        expect_state("R7 irq low", 1'b0);

        // R4: high level on pin 94
        trig_level[94]  = 1'b1;
        trig_invert[94] = 1'b1;
        tick(3);
        expect_state("R4 high idle", 1'b0);
        pin_in[94] = 1'b1;
        tick(3);
        es = bit_at(94);
        expect_state("R4 high sets", 1'b0);
        tick(1);
        expect_state("R4 high irq", 1'b1);
        wr(8'h88, 32'h4000_0000);
        expect_state("R4 event wins over clear", 1'b1);
        pin_in[94] = 1'b0;
        tick(3);
        expect_state("R4 sticky after level gone", 1'b1);
        wr(8'h88, 32'h4000_0000);
        es = '0;
        expect_state("R4 cleared", 1'b1);
        tick(1);
        expect_state("R7 low after R4", 1'b0);

        // R4: low level on pin 5, pin already low
        trig_level[5] = 1'b1;
        tick(1);
        es = bit_at(5);
        expect_state("R4 low sets at once", 1'b0);
        pin_in[5] = 1'b1;
        tick(3);
        wr(8'h80, 32'h20);
        es = '0;
        expect_state("R4 low clear", 1'b1);
        tick(2);
        expect_state("R4 low stays clear", 1'b0);

        // R8: sensing off
        sense_off[10] = 1'b1;
        pin_in[10] = 1'b1;
        tick(4);
        expect_state("R8 edge blocked", 1'b0);
        sense_off[10] = 1'b0;
        tick(3);
        expect_state("R8 no late edge", 1'b0);
        sense_off[11]  = 1'b1;
        trig_level[11] = 1'b1;
        tick(3);
        expect_state("R8 level blocked", 1'b0);

        // R6: other addresses and word replacement
        wr(8'h8C, 32'hFFFF_FFFF);
        wr(8'hA0, 32'hFFFF_FFFF);
        wr(8'h9C, 32'hFFFF_FFFF);
        expect_state("R6 stray addresses ignored", 1'b0);
        wr(8'h90, 32'h1);
        ee[31:0] = 32'h1;
        expect_state("R6 word replaced", 1'b0);

        tick(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule